// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block keeps every uop that has been issued but not yet committed, in program order, inside a circular buffer of 40 slots. The slot index given to a uop when it enters is also its physical register name, so a rename stage can point consumers at the slot. Up to four uops enter per cycle as one group. Execution units report results, together with an exception flag and a mispredict flag, through two writeback ports, in any order.

Two read ports let the operand lookup logic fetch a result by physical register name. Each cycle, up to four of the oldest entries retire and hand their architectural destination and result to the architectural register file. Retirement follows a prefix rule: it covers the entries from the head onward and stops at the first one that cannot retire.

When the oldest entry has executed with an exception or mispredict flag set, it does not retire. Instead, the whole buffer is discarded in that cycle. A flush pulse tells the rename stage to point every register back at architectural state.

Top module: `rob_core`

## Requirements
- R1: After synchronous reset, `empty_o` is 1, `full_o` is 0, no retire slot is valid, `flush_o` is 0 and `alloc_idx_o[0]` is 0.
- R2: Slot k of an allocation group receives index (tail + k) mod 40, shown on `alloc_idx_o[k]` before the edge, so indices run consecutively and wrap from 39 to 0. That index is the uop's physical register name.
- R3: `alloc_ok_o` is 0, and no entry is taken, when `alloc_cnt_i` exceeds the number of free slots counted before this cycle's retirement, or when `flush_o` is 1. `full_o` is 1 exactly when 40 entries are held, and `empty_o` is 1 exactly when none are held.
- R4: A writeback marks its target entry executed and stores its data and flags, one cycle after the port is driven, in any order across entries. A writeback to an index that holds no live entry is ignored.
- R5: A read port returns `rd_ready_o`=1 with the stored data when the named entry is live and executed. Otherwise it returns `rd_ready_o`=0.
- R6: Retire slot k (bit k of `ret_valid_o`, with `ret_areg_o[k]` and `ret_data_o[k]`) carries entry head+k. The valid bits form a prefix that ends at the first entry not yet executed or carrying a flag. An entry can first retire in the cycle after its writeback.
- R7: A retired entry is reclaimed: the head advances past it, and a read of its index reports not ready. After every entry retires, `empty_o` returns to 1.
- R8: When the head entry has executed with a flag set, `flush_o` is 1 for that cycle and no slot retires. `flush_exc_o` is 1 if the exception flag is set, with priority over mispredict, and 0 for a mispredict alone. In the next cycle the buffer is empty and allocation restarts at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_cnt_i | input | 3 | Number of uops requested this cycle (0 to 4) |
| alloc_areg_i | input | 4x3 | Architectural destination per allocation slot |
| alloc_ok_o | output | 1 | Group accepted this cycle |
| alloc_idx_o | output | 4x6 | Entry index (physical register) per allocation slot |
| wb_valid_i | input | 2 | Writeback port valid |
| wb_idx_i | input | 2x6 | Writeback target entry |
| wb_data_i | input | 2x32 | Writeback result |
| wb_exc_i | input | 2 | Writeback exception flag |
| wb_misp_i | input | 2 | Writeback mispredict flag |
| rd_idx_i | input | 2x6 | Source lookup index |
| rd_ready_o | output | 2 | Source value available |
| rd_data_o | output | 2x32 | Source value |
| ret_valid_o | output | 4 | Retire slot valid (prefix) |
| ret_areg_o | output | 4x3 | Retire slot architectural destination |
| ret_data_o | output | 4x32 | Retire slot value |
| flush_o | output | 1 | Buffer discarded this cycle |
| flush_exc_o | output | 1 | Flush cause: 1 exception, 0 mispredict |
| full_o | output | 1 | 40 entries held |
| empty_o | output | 1 | No entries held |

## Verification
Allocation grants and indices, read-port results, retire slots and the flush pulse are all combinational from registered state, so the bench checks them in the same cycle as the inputs that produce them. It drives inputs on the falling edge and samples one time unit later. A writeback becomes visible one rising edge later, on the read ports and in retirement. A flush empties the buffer one edge after the pulse. The bench therefore checks each effect in the cycle after its cause, before the next rising edge. The table rows are cycle-exact, so each expected retire count already includes that one-cycle delay.

// File: rtl/rob_pkg.sv
package rob_pkg;
    localparam int unsigned ROB_DEPTH = 40;
    localparam int unsigned GROUP_N   = 4;
    localparam int unsigned WB_N      = 2;
    localparam int unsigned RD_N      = 2;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned AREG_N    = 8;

    localparam int unsigned IDX_W  = $clog2(ROB_DEPTH);
    localparam int unsigned OCC_W  = $clog2(ROB_DEPTH + 1);
    localparam int unsigned CNT_W  = $clog2(GROUP_N + 1);
    localparam int unsigned AREG_W = $clog2(AREG_N);

    typedef struct packed {
        logic              live;
        logic              done;
        logic              exc;
        logic              misp;
        logic [AREG_W-1:0] areg;
        logic [DATA_W-1:0] data;
    } rob_entry_t;

    function automatic logic [IDX_W-1:0] idx_add(input logic [IDX_W-1:0] base,
                                                  input int unsigned off);
        int unsigned s;
        s = 32'(base) + off;
        if (s >= ROB_DEPTH) s = s - ROB_DEPTH;
        return IDX_W'(s);
    endfunction
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl
    import rob_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] alloc_cnt,
    input  logic [CNT_W-1:0] ret_cnt,
    input  logic             flush,
    output logic             alloc_ok,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [OCC_W-1:0] occ,
    output logic             full,
    output logic             empty
);
    logic [OCC_W-1:0] free_slots;
    logic [OCC_W-1:0] add_cnt;

    always_comb begin
        free_slots = OCC_W'(ROB_DEPTH) - occ;
        alloc_ok   = !flush && (OCC_W'(alloc_cnt) <= free_slots);
        add_cnt    = alloc_ok ? OCC_W'(alloc_cnt) : '0;
        full       = (occ == OCC_W'(ROB_DEPTH));
        empty      = (occ == '0);
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            head <= '0;
            tail <= '0;
            occ  <= '0;
        end else begin
            head <= idx_add(head, 32'(ret_cnt));
            tail <= idx_add(tail, 32'(add_cnt));
            occ  <= occ + add_cnt - OCC_W'(ret_cnt);
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        occ <= OCC_W'(ROB_DEPTH));

    assert_retire_within_occ_R6: assert property (@(posedge clk) disable iff (rst)
        OCC_W'(ret_cnt) <= occ);

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (occ == '0) && (head == '0) && (tail == '0));
endmodule

// File: rtl/rob_retire_sel.sv
module rob_retire_sel
    import rob_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [OCC_W-1:0]   occ,
    input  logic [GROUP_N-1:0] hd_done,
    input  logic [GROUP_N-1:0] hd_exc,
    input  logic [GROUP_N-1:0] hd_misp,
    output logic [GROUP_N-1:0] ret_mask,
    output logic [CNT_W-1:0]   ret_cnt,
    output logic               flush,
    output logic               flush_exc
);
    logic run;

    always_comb begin
        run     = 1'b1;
        ret_cnt = '0;
        for (int k = 0; k < int'(GROUP_N); k++) begin
            run = run && (32'(k) < 32'(occ)) && hd_done[k] && !hd_exc[k] && !hd_misp[k];
            ret_mask[k] = run;
            ret_cnt     = ret_cnt + CNT_W'(run);
        end
        flush     = (occ != '0) && hd_done[0] && (hd_exc[0] || hd_misp[0]);
        flush_exc = flush && hd_exc[0];
    end

    assert_prefix_R6: assert property (@(posedge clk) disable iff (rst)
        (ret_mask & (ret_mask + 1'b1)) == '0);

    assert_flush_no_retire_R8: assert property (@(posedge clk) disable iff (rst)
        flush |-> (ret_mask == '0));
endmodule

// File: rtl/rob_store.sv
module rob_store
    import rob_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          alloc_ok,
    input  logic [CNT_W-1:0]              alloc_cnt,
    input  logic [IDX_W-1:0]              tail,
    input  logic [GROUP_N-1:0][AREG_W-1:0] alloc_areg,
    input  logic [WB_N-1:0]               wb_valid,
    input  logic [WB_N-1:0][IDX_W-1:0]    wb_idx,
    input  logic [WB_N-1:0][DATA_W-1:0]   wb_data,
    input  logic [WB_N-1:0]               wb_exc,
    input  logic [WB_N-1:0]               wb_misp,
    input  logic [IDX_W-1:0]              head,
    input  logic [GROUP_N-1:0]            ret_mask,
    input  logic [RD_N-1:0][IDX_W-1:0]    rd_idx,
    output logic [RD_N-1:0]               rd_ready,
    output logic [RD_N-1:0][DATA_W-1:0]   rd_data,
    output rob_entry_t                    head_ent [GROUP_N]
);
    rob_entry_t       ent [ROB_DEPTH];
    logic [IDX_W-1:0] ret_idx [GROUP_N];
    logic [WB_N-1:0]  wb_hit;

    always_comb begin
        for (int k = 0; k < int'(GROUP_N); k++) begin
            ret_idx[k]  = idx_add(head, 32'(k));
            head_ent[k] = ent[ret_idx[k]];
        end
        for (int w = 0; w < int'(WB_N); w++) begin
            wb_hit[w] = wb_valid[w] && (wb_idx[w] < IDX_W'(ROB_DEPTH)) && ent[wb_idx[w]].live;
        end
        for (int r = 0; r < int'(RD_N); r++) begin
            rd_ready[r] = (rd_idx[r] < IDX_W'(ROB_DEPTH)) && ent[rd_idx[r]].live
                          && ent[rd_idx[r]].done;
            rd_data[r]  = rd_ready[r] ? ent[rd_idx[r]].data : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(ROB_DEPTH); i++) ent[i] <= '0;
        end else if (flush) begin
            for (int i = 0; i < int'(ROB_DEPTH); i++) ent[i].live <= 1'b0;
        end else begin
            for (int k = 0; k < int'(GROUP_N); k++) begin
                if (ret_mask[k]) ent[ret_idx[k]].live <= 1'b0;
            end
            for (int w = 0; w < int'(WB_N); w++) begin
                if (wb_hit[w]) begin
                    ent[wb_idx[w]].done <= 1'b1;
                    ent[wb_idx[w]].exc  <= wb_exc[w];
                    ent[wb_idx[w]].misp <= wb_misp[w];
                    ent[wb_idx[w]].data <= wb_data[w];
                end
            end
            for (int k = 0; k < int'(GROUP_N); k++) begin
                if (alloc_ok && (32'(k) < 32'(alloc_cnt))) begin
                    ent[idx_add(tail, 32'(k))] <= '{live: 1'b1, done: 1'b0, exc: 1'b0,
                                                   misp: 1'b0, areg: alloc_areg[k],
                                                   data: '0};
                end
            end
        end
    end

    for (genvar w = 0; w < int'(WB_N); w++) begin : g_wb_chk
        assert_wb_marks_done_R4: assert property (@(posedge clk) disable iff (rst)
            (wb_hit[w] && !flush) |=> ent[$past(wb_idx[w])].done);
    end

    for (genvar k = 0; k < int'(GROUP_N); k++) begin : g_ret_chk
        assert_retire_reclaims_R7: assert property (@(posedge clk) disable iff (rst)
            ret_mask[k] |=> !ent[$past(ret_idx[k])].live);
    end
endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
(
    input  logic                                     clk,
    input  logic                                     rst,
    input  logic [rob_pkg::CNT_W-1:0]                alloc_cnt_i,
    input  logic [rob_pkg::GROUP_N-1:0][rob_pkg::AREG_W-1:0] alloc_areg_i,
    output logic                                     alloc_ok_o,
    output logic [rob_pkg::GROUP_N-1:0][rob_pkg::IDX_W-1:0]  alloc_idx_o,
    input  logic [rob_pkg::WB_N-1:0]                 wb_valid_i,
    input  logic [rob_pkg::WB_N-1:0][rob_pkg::IDX_W-1:0]     wb_idx_i,
    input  logic [rob_pkg::WB_N-1:0][rob_pkg::DATA_W-1:0]    wb_data_i,
    input  logic [rob_pkg::WB_N-1:0]                 wb_exc_i,
    input  logic [rob_pkg::WB_N-1:0]                 wb_misp_i,
    input  logic [rob_pkg::RD_N-1:0][rob_pkg::IDX_W-1:0]     rd_idx_i,
    output logic [rob_pkg::RD_N-1:0]                 rd_ready_o,
    output logic [rob_pkg::RD_N-1:0][rob_pkg::DATA_W-1:0]    rd_data_o,
    output logic [rob_pkg::GROUP_N-1:0]              ret_valid_o,
    output logic [rob_pkg::GROUP_N-1:0][rob_pkg::AREG_W-1:0] ret_areg_o,
    output logic [rob_pkg::GROUP_N-1:0][rob_pkg::DATA_W-1:0] ret_data_o,
    output logic                                     flush_o,
    output logic                                     flush_exc_o,
    output logic                                     full_o,
    output logic                                     empty_o
);
    logic [IDX_W-1:0]   head, tail;
    logic [OCC_W-1:0]   occ;
    logic [CNT_W-1:0]   ret_cnt;
    logic [GROUP_N-1:0] ret_mask;
    logic [GROUP_N-1:0] hd_done, hd_exc, hd_misp;
    rob_entry_t         head_ent [GROUP_N];

    rob_ptr_ctrl u_ptr (
        .clk       (clk),
        .rst       (rst),
        .alloc_cnt (alloc_cnt_i),
        .ret_cnt   (ret_cnt),
        .flush     (flush_o),
        .alloc_ok  (alloc_ok_o),
        .head      (head),
        .tail      (tail),
        .occ       (occ),
        .full      (full_o),
        .empty     (empty_o)
    );

    rob_store u_store (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush_o),
        .alloc_ok   (alloc_ok_o),
        .alloc_cnt  (alloc_cnt_i),
        .tail       (tail),
        .alloc_areg (alloc_areg_i),
        .wb_valid   (wb_valid_i),
        .wb_idx     (wb_idx_i),
        .wb_data    (wb_data_i),
        .wb_exc     (wb_exc_i),
        .wb_misp    (wb_misp_i),
        .head       (head),
        .ret_mask   (ret_mask),
        .rd_idx     (rd_idx_i),
        .rd_ready   (rd_ready_o),
        .rd_data    (rd_data_o),
        .head_ent   (head_ent)
    );

    always_comb begin
        for (int k = 0; k < int'(GROUP_N); k++) begin
            hd_done[k]     = head_ent[k].done;
            hd_exc[k]      = head_ent[k].exc;
            hd_misp[k]     = head_ent[k].misp;
            ret_areg_o[k]  = head_ent[k].areg;
            ret_data_o[k]  = head_ent[k].data;
            alloc_idx_o[k] = idx_add(tail, 32'(k));
        end
        ret_valid_o = ret_mask;
    end

    rob_retire_sel u_ret (
        .clk       (clk),
        .rst       (rst),
        .occ       (occ),
        .hd_done   (hd_done),
        .hd_exc    (hd_exc),
        .hd_misp   (hd_misp),
        .ret_mask  (ret_mask),
        .ret_cnt   (ret_cnt),
        .flush     (flush_o),
        .flush_exc (flush_exc_o)
    );

    assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (rst)
        !(full_o && empty_o));

    assert_refuse_on_flush_R3: assert property (@(posedge clk) disable iff (rst)
        flush_o |-> !alloc_ok_o);
endmodule

// File: tb/rob_core_tb_top.sv
module rob_core_tb_top;
    import rob_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0] acnt;
        logic       wbv;
        logic [5:0] wbidx;
        logic       wbmisp;
        logic       ok;
        logic [2:0] ret;
        logic       fl;
    } vec_t;

    // Cycle-exact scenario: prefix retirement, out-of-order writeback, mispredict flush (R3, R6, R8)
    localparam vec_t VEC [12] = '{
        '{3'd4, 1'b0, 6'd0, 1'b0, 1'b1, 3'd0, 1'b0},
        '{3'd4, 1'b1, 6'd2, 1'b0, 1'b1, 3'd0, 1'b0},
        '{3'd0, 1'b1, 6'd0, 1'b0, 1'b1, 3'd0, 1'b0},
        '{3'd0, 1'b1, 6'd1, 1'b0, 1'b1, 3'd1, 1'b0},
        '{3'd0, 1'b1, 6'd3, 1'b0, 1'b1, 3'd2, 1'b0},
        '{3'd0, 1'b0, 6'd0, 1'b0, 1'b1, 3'd1, 1'b0},
        '{3'd0, 1'b1, 6'd5, 1'b0, 1'b1, 3'd0, 1'b0},
        '{3'd0, 1'b1, 6'd4, 1'b0, 1'b1, 3'd0, 1'b0},
        '{3'd0, 1'b1, 6'd6, 1'b0, 1'b1, 3'd2, 1'b0},
        '{3'd0, 1'b1, 6'd7, 1'b1, 1'b1, 3'd1, 1'b0},
        '{3'd0, 1'b0, 6'd0, 1'b0, 1'b0, 3'd0, 1'b1},
        '{3'd3, 1'b0, 6'd0, 1'b0, 1'b1, 3'd0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [CNT_W-1:0]                 alloc_cnt_i = '0;
    logic [GROUP_N-1:0][AREG_W-1:0]   alloc_areg_i;
    logic                             alloc_ok_o;
    logic [GROUP_N-1:0][IDX_W-1:0]    alloc_idx_o;
    logic [WB_N-1:0]                  wb_valid_i = '0;
    logic [WB_N-1:0][IDX_W-1:0]       wb_idx_i   = '0;
    logic [WB_N-1:0][DATA_W-1:0]      wb_data_i  = '0;
    logic [WB_N-1:0]                  wb_exc_i   = '0;
    logic [WB_N-1:0]                  wb_misp_i  = '0;
    logic [RD_N-1:0][IDX_W-1:0]       rd_idx_i   = '0;
    logic [RD_N-1:0]                  rd_ready_o;
    logic [RD_N-1:0][DATA_W-1:0]      rd_data_o;
    logic [GROUP_N-1:0]               ret_valid_o;
    logic [GROUP_N-1:0][AREG_W-1:0]   ret_areg_o;
    logic [GROUP_N-1:0][DATA_W-1:0]   ret_data_o;
    logic flush_o, flush_exc_o, full_o, empty_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rob_core dut_i (.*);

    task automatic check(input string tag, input int unsigned act, input int unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        alloc_cnt_i = '0;
        wb_valid_i  = '0;
        wb_exc_i    = '0;
        wb_misp_i   = '0;
    endtask

    initial begin
        for (int k = 0; k < int'(GROUP_N); k++) alloc_areg_i[k] = AREG_W'(k + 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 empty after reset", 32'(empty_o), 1);
        check("R1 full after reset", 32'(full_o), 0);
        check("R1 retire after reset", 32'(ret_valid_o), 0);
        check("R1 flush after reset", 32'(flush_o), 0);
        check("R1 first index", 32'(alloc_idx_o[0]), 0);

        // table walk
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            quiet();
            alloc_cnt_i   = VEC[i].acnt;
            wb_valid_i[0] = VEC[i].wbv;
            wb_idx_i[0]   = VEC[i].wbidx;
            wb_data_i[0]  = 32'hA000 + 32'(VEC[i].wbidx);
            wb_misp_i[0]  = VEC[i].wbmisp;
            #1;
            check($sformatf("R3 row %0d alloc_ok", i), 32'(alloc_ok_o), 32'(VEC[i].ok));
            check($sformatf("R6 row %0d retire count", i), $countones(ret_valid_o), 32'(VEC[i].ret));
            check($sformatf("R8 row %0d flush", i), 32'(flush_o), 32'(VEC[i].fl));
            if (VEC[i].fl) check("R8 mispredict cause", 32'(flush_exc_o), 0);
        end

        // fill to full: 3 held, tail at 3
        for (int j = 0; j < 9; j++) begin
            @(negedge clk);
            quiet();
            alloc_cnt_i = 3'd4;
            #1;
            check("R2 consecutive index", 32'(alloc_idx_o[0]), 32'(3 + 4*j));
            check("R3 fill accepted", 32'(alloc_ok_o), 1);
        end
        @(negedge clk);
        alloc_cnt_i = 3'd4;
        #1;
        check("R3 group refused with 1 free", 32'(alloc_ok_o), 0);
        check("R2 index wraps to 0", 32'(alloc_idx_o[1]), 0);
        check("R3 not yet full", 32'(full_o), 0);
        @(negedge clk);
        alloc_cnt_i = 3'd1;
        #1;
        check("R3 refused group left state alone", 32'(alloc_idx_o[0]), 39);
        check("R3 single accepted", 32'(alloc_ok_o), 1);
        @(negedge clk);
        alloc_cnt_i = 3'd1;
        #1;
        check("R3 full flag", 32'(full_o), 1);
        check("R3 refused when full", 32'(alloc_ok_o), 0);

        // writeback in reverse order; nothing retires until head executes
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            quiet();
            wb_valid_i  = 2'b11;
            wb_idx_i[0] = IDX_W'(39 - 2*c);
            wb_idx_i[1] = IDX_W'(38 - 2*c);
            wb_data_i[0] = 32'hA000 + 32'(39 - 2*c);
            wb_data_i[1] = 32'hA000 + 32'(38 - 2*c);
            if (c == 5) begin
                rd_idx_i[0] = IDX_W'(39);
                rd_idx_i[1] = IDX_W'(0);
            end
            #1;
            check("R6 blocked by unexecuted head", 32'(ret_valid_o), 0);
            if (c == 5) begin
                check("R5 executed entry ready", 32'(rd_ready_o[0]), 1);
                check("R5 executed entry data", rd_data_o[0], 32'hA027);
                check("R5 pending entry not ready", 32'(rd_ready_o[1]), 0);
            end
        end

        // drain four per cycle
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            quiet();
            #1;
            check("R6 full retire group", 32'(ret_valid_o), 32'hF);
            for (int k = 0; k < 4; k++)
                check("R6 retire data", ret_data_o[k], 32'hA000 + 32'(4*c + k));
        end
        @(negedge clk);
        rd_idx_i[0] = IDX_W'(5);
        #1;
        check("R7 empty after drain", 32'(empty_o), 1);
        check("R7 retired entry not ready", 32'(rd_ready_o[0]), 0);

        // writeback to a dead entry is ignored
        @(negedge clk);
        wb_valid_i   = 2'b01;
        wb_idx_i[0]  = IDX_W'(20);
        wb_data_i[0] = 32'h1234;
        @(negedge clk);
        quiet();
        rd_idx_i[0] = IDX_W'(20);
        #1;
        check("R4 dead writeback ignored", 32'(rd_ready_o[0]), 0);

        // destination and data carried to retire; out-of-order writeback
        @(negedge clk);
        alloc_cnt_i = 3'd2;
        alloc_areg_i[0] = AREG_W'(5);
        alloc_areg_i[1] = AREG_W'(6);
        #1;
        check("R2 index after wrap", 32'(alloc_idx_o[0]), 0);
        check("R2 second index", 32'(alloc_idx_o[1]), 1);
        @(negedge clk);
        quiet();
        wb_valid_i = 2'b01; wb_idx_i[0] = IDX_W'(1); wb_data_i[0] = 32'h22;
        @(negedge clk);
        wb_valid_i = 2'b01; wb_idx_i[0] = IDX_W'(0); wb_data_i[0] = 32'h11;
        #1;
        check("R6 younger done, head pending", 32'(ret_valid_o), 0);
        @(negedge clk);
        quiet();
        #1;
        check("R6 two retire", 32'(ret_valid_o), 32'h3);
        check("R6 retire areg 0", 32'(ret_areg_o[0]), 5);
        check("R6 retire areg 1", 32'(ret_areg_o[1]), 6);
        check("R4 data slot 0", ret_data_o[0], 32'h11);
        check("R4 data slot 1", ret_data_o[1], 32'h22);

        // exception at head with mispredict too: exception wins
        @(negedge clk);
        alloc_cnt_i = 3'd3;
        #1;
        check("R2 index after retire", 32'(alloc_idx_o[0]), 2);
        @(negedge clk);
        quiet();
        wb_valid_i = 2'b11;
        wb_idx_i[0] = IDX_W'(3); wb_data_i[0] = 32'h33;
        wb_idx_i[1] = IDX_W'(2); wb_data_i[1] = 32'h44;
        wb_exc_i[1] = 1'b1; wb_misp_i[1] = 1'b1;
        @(negedge clk);
        quiet();
        alloc_cnt_i = 3'd1;
        rd_idx_i[0] = IDX_W'(3);
        #1;
        check("R8 flush on exception", 32'(flush_o), 1);
        check("R8 exception cause priority", 32'(flush_exc_o), 1);
        check("R8 no retire on flush", 32'(ret_valid_o), 0);
        check("R3 refused during flush", 32'(alloc_ok_o), 0);
        @(negedge clk);
        quiet();
        #1;
        check("R8 empty after flush", 32'(empty_o), 1);
        check("R8 index restarts", 32'(alloc_idx_o[0]), 0);
        check("R8 younger entry discarded", 32'(rd_ready_o[0]), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule